// File: doc/BRIEF.md
# Power-Up Sequencing Controller

This block is the digital sequencer of a multi-rail power controller. It waits for the standby bias to come out of power-on reset, then waits for every main input rail to report that it is above its undervoltage threshold. A start-up delay follows. When the delay ends, the sequencer runs a soft-start ramp as an 8-bit code and releases the pull-down on the external dual-rail switch. Once the ramp has peaked it steps the code down to a lower hold level and stays there until the system asks for sleep.

The regulators, pass devices and comparators sit outside the block and reach it only as digital flags. A strap input selects when auxiliary rail 1 is enabled. With the strap high, the rail comes up together with the standby rail as soon as bias is valid. With the strap low, it waits for the ramp and comes up with the low-voltage rail. The delay length, the ramp step period and the peak and hold codes are parameters counted in clock cycles and code units.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset, and in the cycle after `biasOk` is seen low in any phase, `phaseCode` is 0 (wait for bias), `rampCode` is 0, all three enables are 0 and `swHoldLow` is 1.
- R2: With `auxStrap` high, one cycle after `biasOk` is seen high, `phaseCode` becomes 1 (wait for inputs) and `stbyEn` and `aux1En` are both 1.
- R3: With `auxStrap` low, `aux1En` stays 0 through phases 1 and 2 and rises in the first ramp cycle, the same cycle as `lvEn`.
- R4: Phase 2 (delay) is entered only when every bit of `mainOk` is 1, and it lasts exactly `DELAY_CYCLES` cycles when the inputs stay valid.
- R5: If any `mainOk` bit is 0 during the delay, the next phase is 1, and a later return to the delay counts the full `DELAY_CYCLES` again.
- R6: In the first cycle of phase 3 (ramp), `rampCode` is 0, `lvEn` is 1 and `swHoldLow` is 0.
- R7: During the ramp, `rampCode` rises by one every `RAMP_DIV` cycles. The ramp phase lasts `PEAK_CODE*RAMP_DIV+1` cycles.
- R8: The cycle after `rampCode` equals `PEAK_CODE`, `phaseCode` is 4 (hold) and `rampCode` equals `HOLD_CODE`.
- R9: In hold, `rampCode` does not change while `sleepReq` is 0. One cycle after `sleepReq` is seen high, `phaseCode` is 5 (sleep), `rampCode` is 0, `lvEn` is 0 and `swHoldLow` is 1.
- R10: In sleep, when `sleepReq` is seen low, the sequencer returns to phase 1 and starts a new delay if the inputs are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| biasOk | input | 1 | Standby bias is above its power-on-reset level |
| mainOk | input | NUM_MAIN | Per-rail above-undervoltage flags for the main inputs |
| auxStrap | input | 1 | 1: aux rail 1 comes up with bias; 0: aux rail 1 comes up at ramp start |
| sleepReq | input | 1 | Sleep-state request |
| stbyEn | output | 1 | Standby-derived rail enable |
| aux1En | output | 1 | Auxiliary rail 1 enable |
| lvEn | output | 1 | Low-voltage rail enable |
| swHoldLow | output | 1 | 1: pull the external dual-rail switch control low |
| rampCode | output | CODE_W | Soft-start ramp code |
| phaseCode | output | 3 | Phase: 0 wait bias, 1 wait inputs, 2 delay, 3 ramp, 4 hold, 5 sleep |

## Verification
The stimulus table walks the full bring-up with the strap high: bias alone, partial inputs, all inputs, ramp, hold, sleep, wake and bias loss. This shows that each phase is entered only on its own condition. The delay is also run with a one-cycle dropout on a single input. This separates a timer that restarts from one that merely pauses. With the strap low, the aux rail enable is compared against the low-voltage enable cycle by cycle. The ramp is sampled every cycle to confirm the step period, the single-cycle peak and the exact hold code, and bias is dropped in mid-ramp to confirm the immediate return to the idle state.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    PH_WAIT_BIAS = 3'd0,
    PH_WAIT_IN   = 3'd1,
    PH_DELAY     = 3'd2,
    PH_RAMP      = 3'd3,
    PH_HOLD      = 3'd4,
    PH_SLEEP     = 3'd5
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic timerClr;
    logic rampRun;
    logic codeClr;
    logic codeLoadHold;
  } seq_strobe_t;

endpackage

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int DELAY_CYCLES = 2_500_000,
  parameter int RAMP_DIV     = 64,
  parameter int CODE_W       = 8,
  parameter int PEAK_CODE    = 153,
  parameter int HOLD_CODE    = 138
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       stb,
  output logic              timerDone,
  output logic              codeAtPeak,
  output logic [CODE_W-1:0] rampCode
);

  localparam int TIMER_W = $clog2(DELAY_CYCLES + 1);
  localparam int PRE_W   = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;

  logic [TIMER_W-1:0] timer;
  logic [PRE_W-1:0]   pre;
  logic               preWrap;

  assign timerDone  = (timer == TIMER_W'(DELAY_CYCLES - 1));
  assign preWrap    = (pre == PRE_W'(RAMP_DIV - 1));
  assign codeAtPeak = (rampCode == CODE_W'(PEAK_CODE));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer    <= '0;
      pre      <= '0;
      rampCode <= '0;
    end else begin
      if (stb.timerClr)    timer <= '0;
      else if (!timerDone) timer <= timer + 1'b1;

      if (!stb.rampRun || preWrap) pre <= '0;
      else                         pre <= pre + 1'b1;

      if (stb.codeClr)                 rampCode <= '0;
      else if (stb.codeLoadHold)       rampCode <= CODE_W'(HOLD_CODE);
      else if (stb.rampRun && preWrap) rampCode <= rampCode + 1'b1;
    end
  end

  // R4: delay timer never passes its terminal count
  a_r4_timer_bounded: assert property (@(posedge clk) disable iff (!rstN)
    timer < TIMER_W'(DELAY_CYCLES));

  // R8: code never exceeds the peak
  a_r8_code_bounded: assert property (@(posedge clk) disable iff (!rstN)
    rampCode <= CODE_W'(PEAK_CODE));

  // R7: code only steps by one, drops to hold level, or clears
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (rampCode != $past(rampCode)) |->
      (rampCode == $past(rampCode) + 1'b1) || (rampCode == '0) ||
      (rampCode == CODE_W'(HOLD_CODE)));

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NUM_MAIN = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                biasOk,
  input  logic [NUM_MAIN-1:0] mainOk,
  input  logic                auxStrap,
  input  logic                sleepReq,
  input  logic                timerDone,
  input  logic                codeAtPeak,
  output phase_e              phase,
  output seq_strobe_t         stb,
  output logic                stbyEn,
  output logic                aux1En,
  output logic                lvEn,
  output logic                swHoldLow
);

  phase_e phaseNxt;
  logic   allOk;
  logic   ramping;

  assign allOk   = &mainOk;
  assign ramping = (phase == PH_RAMP) || (phase == PH_HOLD);

  always_comb begin
    phaseNxt = phase;
    unique case (phase)
      PH_WAIT_BIAS: if (biasOk) phaseNxt = PH_WAIT_IN;
      PH_WAIT_IN:   if (allOk) phaseNxt = PH_DELAY;
      PH_DELAY: begin
        if (!allOk)         phaseNxt = PH_WAIT_IN;
        else if (timerDone) phaseNxt = PH_RAMP;
      end
      PH_RAMP:  if (codeAtPeak) phaseNxt = PH_HOLD;
      PH_HOLD:  if (sleepReq) phaseNxt = PH_SLEEP;
      PH_SLEEP: if (!sleepReq) phaseNxt = PH_WAIT_IN;
      default:  phaseNxt = PH_WAIT_BIAS;
    endcase
    if (!biasOk) phaseNxt = PH_WAIT_BIAS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_WAIT_BIAS;
    else       phase <= phaseNxt;
  end

  always_comb begin
    stb.timerClr     = !biasOk || (phase != PH_DELAY) || !allOk;
    stb.rampRun      = biasOk && (phase == PH_RAMP) && !codeAtPeak;
    stb.codeLoadHold = biasOk && (phase == PH_RAMP) && codeAtPeak;
    stb.codeClr      = !biasOk || !ramping || ((phase == PH_HOLD) && sleepReq);
  end

  assign stbyEn    = (phase != PH_WAIT_BIAS);
  assign aux1En    = ((phase != PH_WAIT_BIAS) && auxStrap) || ramping;
  assign lvEn      = ramping;
  assign swHoldLow = !ramping;

  // R1: losing bias always returns to the idle phase
  a_r1_bias_loss: assert property (@(posedge clk) disable iff (!rstN)
    !biasOk |=> (phase == PH_WAIT_BIAS));

  // R5: input dropout during the delay goes back to waiting
  a_r5_dropout_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DELAY && biasOk && !allOk) |=> (phase == PH_WAIT_IN));

  // R9: sleep request in hold is honoured the next cycle
  a_r9_hold_to_sleep: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HOLD && biasOk && sleepReq) |=> (phase == PH_SLEEP));

  // R4: the delay phase is entered only with all inputs valid
  a_r4_delay_entry: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DELAY && $past(phase) != PH_DELAY) |-> $past(allOk));

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int NUM_MAIN     = 3,
  parameter int DELAY_CYCLES = 2_500_000,
  parameter int RAMP_DIV     = 64,
  parameter int CODE_W       = 8,
  parameter int PEAK_CODE    = 153,
  parameter int HOLD_CODE    = 138
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                biasOk,
  input  logic [NUM_MAIN-1:0] mainOk,
  input  logic                auxStrap,
  input  logic                sleepReq,
  output logic                stbyEn,
  output logic                aux1En,
  output logic                lvEn,
  output logic                swHoldLow,
  output logic [CODE_W-1:0]   rampCode,
  output logic [2:0]          phaseCode
);

  phase_e      phase;
  seq_strobe_t stb;
  logic        timerDone;
  logic        codeAtPeak;

  pwr_seq_ctrl #(.NUM_MAIN(NUM_MAIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .biasOk(biasOk), .mainOk(mainOk),
    .auxStrap(auxStrap), .sleepReq(sleepReq), .timerDone(timerDone),
    .codeAtPeak(codeAtPeak), .phase(phase), .stb(stb),
    .stbyEn(stbyEn), .aux1En(aux1En), .lvEn(lvEn), .swHoldLow(swHoldLow)
  );

  pwr_seq_dp #(
    .DELAY_CYCLES(DELAY_CYCLES), .RAMP_DIV(RAMP_DIV), .CODE_W(CODE_W),
    .PEAK_CODE(PEAK_CODE), .HOLD_CODE(HOLD_CODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .timerDone(timerDone),
    .codeAtPeak(codeAtPeak), .rampCode(rampCode)
  );

  assign phaseCode = phase;

  // R6: ramp starts from zero with the switch released and the rail on
  a_r6_ramp_start: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RAMP && $past(phase) == PH_DELAY) |->
      (rampCode == '0 && !swHoldLow && lvEn));

  // R8: peak is followed by the hold level
  a_r8_peak_to_hold: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RAMP && biasOk && rampCode == CODE_W'(PEAK_CODE)) |=>
      (phase == PH_HOLD && rampCode == CODE_W'(HOLD_CODE)));

  // R9: hold level is kept while no sleep request arrives
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HOLD && biasOk && !sleepReq) |=> $stable(rampCode));

  // R3: with strap low, aux rail 1 tracks the low-voltage rail
  a_r3_aux_with_lv: assert property (@(posedge clk) disable iff (!rstN)
    !auxStrap |-> (aux1En == lvEn));

endmodule

// File: tb/pwr_seq_top_tb.sv
module pwr_seq_top_tb;

  localparam int NM = 3;
  localparam int DC = 20;
  localparam int DIV = 2;
  localparam int PEAK = 10;
  localparam int HOLDC = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic biasOk = 1'b0;
  logic [NM-1:0] mainOk = '0;
  logic auxStrap = 1'b1;
  logic sleepReq = 1'b0;
  logic stbyEn, aux1En, lvEn, swHoldLow;
  logic [7:0] rampCode;
  logic [2:0] phaseCode;

  int nChecks = 0;
  int nErr = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwr_seq_top #(
    .NUM_MAIN(NM), .DELAY_CYCLES(DC), .RAMP_DIV(DIV), .CODE_W(8),
    .PEAK_CODE(PEAK), .HOLD_CODE(HOLDC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .biasOk(biasOk), .mainOk(mainOk),
    .auxStrap(auxStrap), .sleepReq(sleepReq), .stbyEn(stbyEn),
    .aux1En(aux1En), .lvEn(lvEn), .swHoldLow(swHoldLow),
    .rampCode(rampCode), .phaseCode(phaseCode)
  );

  // {bias, main[2:0], strap, sleep, wait[7:0], phase[2:0], stby, aux, lv, hold, tag[3:0]}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 3'b000, 1'b1, 1'b0, 8'd3,  3'd0, 4'b0001, 4'd1},  // R1 idle
    {1'b1, 3'b011, 1'b1, 1'b0, 8'd2,  3'd1, 4'b1101, 4'd2},  // R2 bias, partial inputs
    {1'b1, 3'b111, 1'b1, 1'b0, 8'd5,  3'd2, 4'b1101, 4'd4},  // R4 delay
    {1'b1, 3'b111, 1'b1, 1'b0, 8'd30, 3'd3, 4'b1110, 4'd6},  // R6 ramp
    {1'b1, 3'b111, 1'b1, 1'b0, 8'd20, 3'd4, 4'b1110, 4'd8},  // R8 hold
    {1'b1, 3'b111, 1'b1, 1'b1, 8'd2,  3'd5, 4'b1101, 4'd9},  // R9 sleep
    {1'b1, 3'b111, 1'b1, 1'b0, 8'd2,  3'd2, 4'b1101, 4'd10}, // R10 wake
    {1'b0, 3'b111, 1'b1, 1'b0, 8'd1,  3'd0, 4'b0001, 4'd1}   // R1 bias lost
  };

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; biasOk = 1'b0; mainOk = '0; sleepReq = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitPhase(input int p);
    for (int i = 0; i < 500 && phaseCode != 3'(p); i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      nErr++;
      $display("FAIL watchdog actual %0d expected 0", cyc);
      $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    int cnt;
    int lastAux;
    doReset();
    // R1: reset state
    chk("R1", phaseCode, 0); chk("R1", rampCode, 0);
    chk("R1", {stbyEn, aux1En, lvEn, swHoldLow}, 4'b0001);

    for (int i = 0; i < 8; i++) begin
      logic [24:0] v;
      v = VEC[i];
      biasOk = v[24]; mainOk = v[23:21]; auxStrap = v[20]; sleepReq = v[19];
      repeat (int'(v[18:11])) @(negedge clk);
      chk($sformatf("R%0d", v[3:0]), phaseCode, int'(v[10:8]));
      chk($sformatf("R%0d", v[3:0]), {stbyEn, aux1En, lvEn, swHoldLow}, int'(v[7:4]));
    end

    // R4 R6 R7 R8 R9: timed bring-up
    doReset();
    auxStrap = 1'b1; biasOk = 1'b1; mainOk = '1;
    waitPhase(2);
    cnt = 0;
    for (int i = 0; i < 500 && phaseCode == 3'd2; i++) begin cnt++; @(negedge clk); end
    chk("R4", cnt, DC);
    chk("R6", phaseCode, 3); chk("R6", rampCode, 0);
    chk("R6", swHoldLow, 0); chk("R6", lvEn, 1);
    cnt = 0;
    for (int i = 0; i < 500 && phaseCode == 3'd3; i++) begin
      chk("R7", rampCode, cnt / DIV);
      cnt++;
      @(negedge clk);
    end
    chk("R7", cnt, PEAK * DIV + 1);
    chk("R8", phaseCode, 4); chk("R8", rampCode, HOLDC);
    repeat (10) @(negedge clk);
    chk("R9", rampCode, HOLDC); chk("R9", phaseCode, 4);
    sleepReq = 1'b1;
    @(negedge clk);
    chk("R9", phaseCode, 5); chk("R9", rampCode, 0);
    chk("R9", lvEn, 0); chk("R9", swHoldLow, 1);

    // R3: strap low
    doReset();
    auxStrap = 1'b0; biasOk = 1'b1; mainOk = '1;
    waitPhase(2);
    chk("R3", aux1En, 0); chk("R3", stbyEn, 1);
    lastAux = 1;
    for (int i = 0; i < 500 && phaseCode != 3'd3; i++) begin
      lastAux = aux1En; @(negedge clk);
    end
    chk("R3", lastAux, 0); chk("R3", aux1En, 1); chk("R3", lvEn, 1);

    // R5: one-cycle dropout restarts the delay
    doReset();
    auxStrap = 1'b1; biasOk = 1'b1; mainOk = '1;
    waitPhase(2);
    repeat (10) @(negedge clk);
    mainOk = 3'b101;
    @(negedge clk);
    chk("R5", phaseCode, 1);
    mainOk = '1;
    @(negedge clk);
    chk("R5", phaseCode, 2);
    cnt = 0;
    for (int i = 0; i < 500 && phaseCode == 3'd2; i++) begin cnt++; @(negedge clk); end
    chk("R5", cnt, DC);

    // R1: bias lost mid-ramp
    repeat (5) @(negedge clk);
    chk("R1", phaseCode, 3);
    biasOk = 1'b0;
    @(negedge clk);
    chk("R1", phaseCode, 0); chk("R1", rampCode, 0);
    chk("R1", {stbyEn, aux1En, lvEn, swHoldLow}, 4'b0001);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

endmodule